// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This block decides who drives a shared external memory bus: the internal memory controller or an outside requester. The requester asks for the bus by pulling an active-low request low. The block then stops new internal transactions from starting and waits for any transaction already running to finish. It turns off the single output-enable that covers the whole bus group (4 chip selects, 4 byte strobes, 32 data lines, address bits 21 to 2, and three control strobes), and only then pulls its active-low acknowledge low. When the requester lets the request go high again, the block drives the bus first and raises the acknowledge after that.

The request pin is asynchronous and goes through a two-stage synchronizer. The delay of the synchronizer counts toward the minimum time the handover has to take. A configuration bit can keep the block from handing over the bus for as long as the bit is set. A single-cycle error pulse is raised when the requester lets go of the request too soon after the acknowledge.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset, `hold_ack_n` is 1, `bus_oe` is 1, `proto_err` is 0 and `start_grant` follows `start_pend`.
- R2: With no internal transaction running and `no_release` at 0, `bus_oe` falls on the 4th rising edge after `hold_req_n` is driven low. This gives at least 2 clock periods between the request and the bus going to high impedance.
- R3: While `xact_busy` is 1, `bus_oe` stays 1. It falls on the 1st edge after `xact_busy` returns to 0.
- R4: `hold_ack_n` falls exactly one cycle after `bus_oe` falls, so the bus is never acknowledged while it is still driven.
- R5: After `hold_req_n` returns high, `bus_oe` rises on the 3rd rising edge, which is inside the 2-to-7 period window. `hold_ack_n` rises one cycle after that.
- R6: While `no_release` is 1, a pending request is never granted: `bus_oe` and `hold_ack_n` both stay 1.
- R7: `start_grant` equals `start_pend` only while the block owns the bus and no handover has begun. It is 0 from the start of draining until ownership is restored.
- R8: If the request rises less than one clock period after `hold_ack_n` falls, `proto_err` pulses high for one cycle. A request held low for one period or longer gives no pulse.
- R9: If the request is withdrawn while the block is still draining, the block goes back to owning the bus without ever lowering `bus_oe` or `hold_ack_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_req_n | input | 1 | Asynchronous active-low bus request from the external requester |
| no_release | input | 1 | When 1, the bus is not handed over |
| xact_busy | input | 1 | An internal bus transaction is in progress |
| start_pend | input | 1 | The internal controller wants to start a transaction |
| start_grant | output | 1 | The internal controller may start the transaction now |
| bus_oe | output | 1 | Common output enable for the whole external bus group |
| hold_ack_n | output | 1 | Active-low acknowledge to the requester |
| proto_err | output | 1 | One-cycle pulse when the request is released too early |

## Verification
The assertions check the ordering rules on every cycle:
- The acknowledge falls only after the bus has been off for a full cycle.
- The acknowledge rises only after the bus has been driven for a full cycle.
- The bus is released only when no transaction is running and the block is not held by `no_release`.
- A start is granted only while the block fully owns the bus.

Only the bench scenarios can show the following:
- The exact edge counts of each handover.
- Indefinite deferral under `no_release`.
- Abort of a request during the drain.
- The difference between an early release, which pulses the error, and a legal release, which does not.

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic no_release,
  input  logic xact_busy,
  input  logic start_pend,
  output logic start_grant,
  output logic bus_oe,
  output logic hold_ack_n,
  output logic proto_err
);

  localparam int GCNT_MAX = SYNC_STAGES + 1;
  localparam int GCNT_W   = $clog2(GCNT_MAX + 1);

  typedef enum logic [2:0] {
    ST_OWNED, ST_DRAIN, ST_REL_WAIT, ST_GRANTED, ST_REDRIVE
  } hold_state_t;

  hold_state_t state, state_nx;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [GCNT_W-1:0]      gcnt;
  logic                   hold_s;

  assign hold_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], hold_req_n};

  always_comb begin
    state_nx = state;
    case (state)
      ST_OWNED:    if (!hold_s) state_nx = ST_DRAIN;
      ST_DRAIN:    if (hold_s) state_nx = ST_OWNED;
                   else if (!xact_busy && !no_release) state_nx = ST_REL_WAIT;
      ST_REL_WAIT: state_nx = ST_GRANTED;
      ST_GRANTED:  if (hold_s) state_nx = ST_REDRIVE;
      ST_REDRIVE:  state_nx = ST_OWNED;
      default:     state_nx = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= ST_OWNED;
      gcnt      <= '0;
      proto_err <= 1'b0;
    end else begin
      state     <= state_nx;
      proto_err <= (state == ST_GRANTED) && hold_s && (int'(gcnt) <= SYNC_STAGES);
      if (state == ST_GRANTED)
        gcnt <= (int'(gcnt) == GCNT_MAX) ? gcnt : gcnt + 1'b1;
      else
        gcnt <= '0;
    end

  assign bus_oe      = (state == ST_OWNED) || (state == ST_DRAIN) || (state == ST_REDRIVE);
  assign hold_ack_n  = !((state == ST_GRANTED) || (state == ST_REDRIVE));
  assign start_grant = start_pend && (state == ST_OWNED);

  p_ack_after_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> (!bus_oe && $past(!bus_oe)));

  p_drive_before_unack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack_n) |-> (bus_oe && $past(bus_oe)));

  p_release_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> $past(!xact_busy && !no_release));

  p_defer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(no_release && bus_oe) |-> bus_oe);

  p_start_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_grant |-> (hold_ack_n && bus_oe));

  p_float_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> !$past(hold_req_n, 2));

endmodule

// File: tb/test_bus_hold_arbiter.sv
module test_bus_hold_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_req_n = 1'b1;
  logic no_release = 1'b0;
  logic xact_busy = 1'b0;
  logic start_pend = 1'b0;
  logic start_grant, bus_oe, hold_ack_n, proto_err;
  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arbiter i_bus_hold_arbiter (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .no_release(no_release),
    .xact_busy(xact_busy), .start_pend(start_pend), .start_grant(start_grant),
    .bus_oe(bus_oe), .hold_ack_n(hold_ack_n), .proto_err(proto_err)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic grant_idle();
    hold_req_n = 1'b0;
    step(3);
    chk("R2", "oe still driven at edge 3", bus_oe, 1'b1);
    step(1);
    chk("R2", "oe off at edge 4", bus_oe, 1'b0);
    chk("R4", "ack high while floating 1st cycle", hold_ack_n, 1'b1);
    step(1);
    chk("R4", "ack low one cycle later", hold_ack_n, 1'b0);
  endtask

  task automatic release_bus();
    hold_req_n = 1'b1;
    step(2);
    chk("R5", "oe still off at edge 2", bus_oe, 1'b0);
    step(1);
    chk("R5", "oe on at edge 3", bus_oe, 1'b1);
    chk("R5", "ack still low at edge 3", hold_ack_n, 1'b0);
    step(1);
    chk("R5", "ack high at edge 4", hold_ack_n, 1'b1);
    chk("R8", "no error on legal release", proto_err, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1", "reset ack", hold_ack_n, 1'b1);
    chk("R1", "reset oe", bus_oe, 1'b1);
    chk("R1", "reset err", proto_err, 1'b0);
    start_pend = 1'b1; #1;
    chk("R1", "start grant follows pend", start_grant, 1'b1);
    start_pend = 1'b0; #1;
    chk("R1", "start grant low without pend", start_grant, 1'b0);
  endtask

  task automatic t_idle_handover();
    grant_idle();
    start_pend = 1'b1; #1;
    chk("R7", "no start while granted", start_grant, 1'b0);
    start_pend = 1'b0;
    step(4);
    release_bus();
    start_pend = 1'b1; #1;
    chk("R7", "start allowed after return", start_grant, 1'b1);
    start_pend = 1'b0;
  endtask

  task automatic t_drain_busy();
    xact_busy = 1'b1;
    hold_req_n = 1'b0;
    step(3);
    start_pend = 1'b1; #1;
    chk("R7", "no start while draining", start_grant, 1'b0);
    start_pend = 1'b0;
    step(5);
    chk("R3", "oe held while busy", bus_oe, 1'b1);
    chk("R3", "ack held while busy", hold_ack_n, 1'b1);
    xact_busy = 1'b0;
    step(1);
    chk("R3", "oe off one edge after idle", bus_oe, 1'b0);
    step(1);
    chk("R4", "ack low after drain", hold_ack_n, 1'b0);
    step(4);
    release_bus();
  endtask

  task automatic t_nohold();
    no_release = 1'b1;
    hold_req_n = 1'b0;
    step(20);
    chk("R6", "oe kept while deferred", bus_oe, 1'b1);
    chk("R6", "ack kept high while deferred", hold_ack_n, 1'b1);
    no_release = 1'b0;
    step(1);
    chk("R6", "oe off after deferral ends", bus_oe, 1'b0);
    step(1);
    chk("R6", "ack low after deferral ends", hold_ack_n, 1'b0);
    step(4);
    release_bus();
  endtask

  task automatic t_early_release();
    grant_idle();
    hold_req_n = 1'b1;
    step(2);
    chk("R8", "no error before detection", proto_err, 1'b0);
    step(1);
    chk("R8", "error pulse on early release", proto_err, 1'b1);
    step(1);
    chk("R8", "error pulse lasts one cycle", proto_err, 1'b0);
    chk("R5", "ack high after early release", hold_ack_n, 1'b1);
  endtask

  task automatic t_legal_min_release();
    grant_idle();
    step(1);
    hold_req_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk("R8", "no error on release after one period", proto_err, 1'b0);
    end
    chk("R5", "oe on after legal release", bus_oe, 1'b1);
    step(1);
    chk("R8", "no error at return", proto_err, 1'b0);
    chk("R5", "ack high after legal release", hold_ack_n, 1'b1);
  endtask

  task automatic t_abort();
    xact_busy = 1'b1;
    hold_req_n = 1'b0;
    step(4);
    hold_req_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step(1);
      chk("R9", "oe kept during abort", bus_oe, 1'b1);
      chk("R9", "ack kept high during abort", hold_ack_n, 1'b1);
    end
    xact_busy = 1'b0;
    step(3);
    chk("R9", "oe still driven after abort", bus_oe, 1'b1);
    start_pend = 1'b1; #1;
    chk("R9", "owned again after abort", start_grant, 1'b1);
    start_pend = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_idle_handover();
    t_drain_busy();
    t_nohold();
    t_early_release();
    step(3);
    t_legal_min_release();
    step(3);
    t_abort();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule